// File: doc/BRIEF.md
# Network-Interface Transmit Scheduler with Credit Return

This block is the transmit-side scheduler of a network-interface kernel that serves several channels. For each channel it tracks two counts. One is the free room left in the remote destination queue, called the space count. The other is the number of words the local consumer has drained and not yet reported back, called the credit count. A sixteen-entry time-slot table holds reservations for guaranteed-throughput channels. A slot index steps once per flit slot.

On every slot strobe the scheduler first looks at the reserved owner of the current slot. If that owner is eligible, the owner wins. Otherwise a round-robin arbiter picks among the eligible best-effort channels. A channel is eligible when it has data it may send or credits it owes, so a packet may carry credits and no payload.

For the winner the block issues a header. The header holds the channel's route, its remote queue number, the credits returned (capped by the header field) and the payload word count (capped by the maximum packet length). The same edge charges the space and credit counts. Credits that arrive in incoming headers are added back to the space count of the addressed channel.

A small state machine records the outcome of each slot. In `ST_IDLE` there is no grant. `ST_GT_GRANT` holds a reserved-slot grant and `ST_BE_GRANT` holds a round-robin grant. On each clock the next state is chosen from the current slot decision, whatever the previous state was. A strobe whose slot owner is eligible goes to `ST_GT_GRANT`. A strobe with an eligible best-effort channel goes to `ST_BE_GRANT`. Any other cycle goes to `ST_IDLE`.

Top module: `nicr_sched`

## Requirements
- R1: After reset no header is issued, all counts are zero, every channel is best-effort and no slot is reserved. A configuration write sets a channel's class, route and remote queue number, and replaces its space count outright with the given value.
- R2: Each consumption pulse on a channel raises its credit count by one. When a header for that channel is issued, the credits it carries are taken off the credit count on the same edge.
- R3: A channel's sendable amount is the smaller of its source-queue fill level and its space count. A packet's word count is the sendable amount capped at 11 words. The space count drops by the words sent.
- R4: A channel is eligible when its sendable amount or its credit count is non-zero. A header with zero words and non-zero credits is legal. With no eligible channel, a strobe issues no header.
- R5: The slot index starts at 0 and steps by one on each strobe, wrapping after 15. If the current slot entry is reserved and its owner is eligible, the owner is granted with the guaranteed flag set, whatever the owner's class.
- R6: Otherwise the next eligible best-effort-class channel is granted, searching upward (wrapping) from the one after the last best-effort winner. Channel 0 is searched first after reset. Guaranteed-class channels are never picked this way.
- R7: A header carries at most 31 credits (5-bit field). Any excess stays in the credit count for later headers.
- R8: An incoming credit pulse adds its value to the named channel's space count. If the same channel also sends on that edge, both take effect in one update.
- R9: The header fields are valid for exactly the one cycle after the strobe's edge. Cycles without a strobe produce no header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Channel configuration write |
| cfg_ch | input | 2 | Channel being configured |
| cfg_gt | input | 1 | 1 = guaranteed class, 0 = best effort |
| cfg_path | input | 8 | Source route for the channel |
| cfg_qid | input | 2 | Remote queue number |
| cfg_space | input | 6 | Remote buffer size loaded as space count |
| slot_we | input | 1 | Slot table write |
| slot_idx | input | 4 | Slot entry written |
| slot_valid | input | 1 | Entry is a reservation |
| slot_ch | input | 2 | Reserved owner |
| slot_tick | input | 1 | Flit-slot strobe |
| src_level | input | 24 | Source queue fill levels, 6 bits per channel, channel 0 lowest |
| cons_vld | input | 1 | Local consumer drained one word |
| cons_ch | input | 2 | Channel of that word |
| rx_vld | input | 1 | Incoming header carries credits |
| rx_ch | input | 2 | Channel the credits belong to |
| rx_credits | input | 5 | Credit value received |
| tx_vld | output | 1 | Header issued |
| tx_gt | output | 1 | Header won a reserved slot |
| tx_ch | output | 2 | Granted channel |
| tx_path | output | 8 | Route field |
| tx_qid | output | 2 | Remote queue field |
| tx_credits | output | 5 | Credits returned in the header |
| tx_words | output | 4 | Payload words in the packet |

## Verification
Two things can land on one channel in the same cycle. Returned credits from the far side can raise the space count on the edge where a packet lowers it. Local consumption can raise the credit count on the edge where a header drains it. The bench forces both overlaps during a long randomized phase. It sends credit pulses and consumption pulses on every channel on strobe cycles. It also adds a directed phase that builds up more than 31 credits on a payload-free channel. A behavioural model advances its own counters once per edge with all contributions summed. Every header, including the word counts and credit values of later headers, is compared against it, so a lost or doubled update shows up at once.

// File: rtl/ncs_pkg.sv
package ncs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GT_GRANT = 2'd1,
        ST_BE_GRANT = 2'd2
    } sched_state_e;

endpackage

// File: rtl/ncs_slot_table.sv
module ncs_slot_table #(
    parameter int SLOTS = 16,
    parameter int CH_W  = 2,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic             advance,
    output logic             cur_valid,
    output logic [CH_W-1:0]  cur_ch
);

    logic [SLOTS-1:0] rsv_q;
    logic [CH_W-1:0]  own_q [SLOTS];
    logic [IDX_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_q  <= '0;
            slot_q <= '0;
            for (int s = 0; s < SLOTS; s++) own_q[s] <= '0;
        end else begin
            if (wr_en) begin
                rsv_q[wr_idx] <= wr_valid;
                own_q[wr_idx] <= wr_ch;
            end
            if (advance) begin
                slot_q <= (slot_q == IDX_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
            end
        end
    end

    assign cur_valid = rsv_q[slot_q];
    assign cur_ch    = own_q[slot_q];

endmodule

// File: rtl/ncs_rr_pick.sv
module ncs_rr_pick #(
    parameter int N = 4,
    localparam int CH_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic            advance,
    output logic            any,
    output logic [CH_W-1:0] pick
);

    logic [CH_W-1:0] last_q;

    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= N; k++) begin
            if (!any && req[(int'(last_q) + k) % N]) begin
                any  = 1'b1;
                pick = CH_W'((int'(last_q) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= CH_W'(N - 1);
        end else if (advance && any) begin
            last_q <= pick;
        end
    end

    AST_RR_PICK_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[pick]); // R6

endmodule

// File: rtl/ncs_chan.sv
module ncs_chan #(
    parameter int SPC_W     = 6,
    parameter int CRD_W     = 7,
    parameter int CRF_W     = 5,
    parameter int MAX_WORDS = 11,
    parameter int PATH_W    = 8,
    parameter int QID_W     = 2,
    localparam int WRD_W    = $clog2(MAX_WORDS + 1),
    localparam int CRF_MAX  = (1 << CRF_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_gt,
    input  logic [PATH_W-1:0] cfg_path,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [SPC_W-1:0]  cfg_space,
    input  logic [SPC_W-1:0]  level,
    input  logic              cons_inc,
    input  logic              rx_add,
    input  logic [CRF_W-1:0]  rx_cred,
    input  logic              take,
    output logic              is_gt,
    output logic [PATH_W-1:0] path,
    output logic [QID_W-1:0]  qid,
    output logic              eligible,
    output logic [WRD_W-1:0]  pkt_words,
    output logic [CRF_W-1:0]  pkt_creds
);

    logic [SPC_W-1:0]  space_q;
    logic [CRD_W-1:0]  cred_q;
    logic [SPC_W-1:0]  sendable;
    logic [SPC_W:0]    space_sum;
    logic [CRD_W:0]    cred_sum;

    assign sendable  = (level < space_q) ? level : space_q;
    assign pkt_words = (sendable > SPC_W'(MAX_WORDS)) ? WRD_W'(MAX_WORDS) : WRD_W'(sendable);
    assign pkt_creds = (cred_q > CRD_W'(CRF_MAX)) ? CRF_W'(CRF_MAX) : CRF_W'(cred_q);
    assign eligible  = (sendable != '0) || (cred_q != '0);

    always_comb begin
        space_sum = {1'b0, space_q};
        if (rx_add) space_sum = space_sum + (SPC_W+1)'(rx_cred);
        if (take)   space_sum = space_sum - (SPC_W+1)'(pkt_words);
        cred_sum = {1'b0, cred_q};
        if (cons_inc) cred_sum = cred_sum + 1'b1;
        if (take)     cred_sum = cred_sum - (CRD_W+1)'(pkt_creds);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q <= '0;
            cred_q  <= '0;
            is_gt   <= 1'b0;
            path    <= '0;
            qid     <= '0;
        end else begin
            cred_q <= cred_sum[CRD_W-1:0];
            if (cfg_load) begin
                space_q <= cfg_space;
                is_gt   <= cfg_gt;
                path    <= cfg_path;
                qid     <= cfg_qid;
            end else begin
                space_q <= space_sum[SPC_W-1:0];
            end
        end
    end

    AST_NO_OVERSEND: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (SPC_W'(pkt_words) <= space_q && SPC_W'(pkt_words) <= level)); // R3
    AST_SPACE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        !space_sum[SPC_W]); // R8
    AST_CREDIT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        !cred_sum[CRD_W]); // R2

endmodule

// File: rtl/nicr_sched.sv
module nicr_sched
    import ncs_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SLOTS     = 16,
    parameter int SPC_W     = 6,
    parameter int CRD_W     = 7,
    parameter int CRF_W     = 5,
    parameter int MAX_WORDS = 11,
    parameter int PATH_W    = 8,
    parameter int QID_W     = 2,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int WRD_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CH_W-1:0]         cfg_ch,
    input  logic                    cfg_gt,
    input  logic [PATH_W-1:0]       cfg_path,
    input  logic [QID_W-1:0]        cfg_qid,
    input  logic [SPC_W-1:0]        cfg_space,
    input  logic                    slot_we,
    input  logic [IDX_W-1:0]        slot_idx,
    input  logic                    slot_valid,
    input  logic [CH_W-1:0]         slot_ch,
    input  logic                    slot_tick,
    input  logic [NUM_CH*SPC_W-1:0] src_level,
    input  logic                    cons_vld,
    input  logic [CH_W-1:0]         cons_ch,
    input  logic                    rx_vld,
    input  logic [CH_W-1:0]         rx_ch,
    input  logic [CRF_W-1:0]        rx_credits,
    output logic                    tx_vld,
    output logic                    tx_gt,
    output logic [CH_W-1:0]         tx_ch,
    output logic [PATH_W-1:0]       tx_path,
    output logic [QID_W-1:0]        tx_qid,
    output logic [CRF_W-1:0]        tx_credits,
    output logic [WRD_W-1:0]        tx_words
);

    logic [NUM_CH-1:0] elig, is_gt, be_req, take;
    logic [PATH_W-1:0] ch_path  [NUM_CH];
    logic [QID_W-1:0]  ch_qid   [NUM_CH];
    logic [WRD_W-1:0]  ch_words [NUM_CH];
    logic [CRF_W-1:0]  ch_creds [NUM_CH];

    logic            cur_valid, gt_hit, rr_any, grant;
    logic [CH_W-1:0] cur_ch, rr_pick, sel_ch;

    sched_state_e state_q, state_d;

    ncs_slot_table #(.SLOTS(SLOTS), .CH_W(CH_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(slot_we), .wr_idx(slot_idx), .wr_valid(slot_valid), .wr_ch(slot_ch),
        .advance(slot_tick), .cur_valid(cur_valid), .cur_ch(cur_ch)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ncs_chan #(
            .SPC_W(SPC_W), .CRD_W(CRD_W), .CRF_W(CRF_W), .MAX_WORDS(MAX_WORDS),
            .PATH_W(PATH_W), .QID_W(QID_W)
        ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cfg_load(cfg_we && cfg_ch == CH_W'(i)),
            .cfg_gt(cfg_gt), .cfg_path(cfg_path), .cfg_qid(cfg_qid), .cfg_space(cfg_space),
            .level(src_level[i*SPC_W +: SPC_W]),
            .cons_inc(cons_vld && cons_ch == CH_W'(i)),
            .rx_add(rx_vld && rx_ch == CH_W'(i)),
            .rx_cred(rx_credits),
            .take(take[i]),
            .is_gt(is_gt[i]), .path(ch_path[i]), .qid(ch_qid[i]),
            .eligible(elig[i]), .pkt_words(ch_words[i]), .pkt_creds(ch_creds[i])
        );
        assign be_req[i] = elig[i] && !is_gt[i];
        assign take[i]   = grant && (sel_ch == CH_W'(i));
    end

    ncs_rr_pick #(.N(NUM_CH)) u_rr (
        .clk(clk), .rst_n(rst_n), .req(be_req),
        .advance(slot_tick && !gt_hit), .any(rr_any), .pick(rr_pick)
    );

    assign gt_hit = slot_tick && cur_valid && elig[cur_ch];
    assign sel_ch = gt_hit ? cur_ch : rr_pick;
    assign grant  = gt_hit || (slot_tick && rr_any);

    // Next-state decision
    always_comb begin
        state_d = ST_IDLE;
        if (gt_hit)                  state_d = ST_GT_GRANT;
        else if (slot_tick && rr_any) state_d = ST_BE_GRANT;
    end

    // State register and header payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tx_ch      <= '0;
            tx_path    <= '0;
            tx_qid     <= '0;
            tx_credits <= '0;
            tx_words   <= '0;
        end else begin
            state_q <= state_d;
            if (grant) begin
                tx_ch      <= sel_ch;
                tx_path    <= ch_path[sel_ch];
                tx_qid     <= ch_qid[sel_ch];
                tx_credits <= ch_creds[sel_ch];
                tx_words   <= ch_words[sel_ch];
            end
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_IDLE:     begin tx_vld = 1'b0; tx_gt = 1'b0; end
            ST_GT_GRANT: begin tx_vld = 1'b1; tx_gt = 1'b1; end
            ST_BE_GRANT: begin tx_vld = 1'b1; tx_gt = 1'b0; end
            default:     begin tx_vld = 1'b0; tx_gt = 1'b0; end
        endcase
    end

    AST_GT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        gt_hit |=> (tx_vld && tx_gt && tx_ch == $past(cur_ch))); // R5
    AST_SILENT_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> !tx_vld); // R9
    AST_PKT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> (tx_words != '0 || tx_credits != '0)); // R4

endmodule

// File: tb/nicr_sched_tb_top.sv
`timescale 1ns/1ps
module nicr_sched_tb_top;
    localparam int NCH = 4, SPC_W = 6, SLOTS = 16, MAXW = 11, CAP = 31;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_we, cfg_gt, slot_we, slot_valid, slot_tick, cons_vld, rx_vld;
    logic [1:0] cfg_ch, cfg_qid, slot_ch, cons_ch, rx_ch;
    logic [7:0] cfg_path;
    logic [5:0] cfg_space;
    logic [3:0] slot_idx;
    logic [4:0] rx_credits;
    logic [NCH*SPC_W-1:0] src_level;
    logic tx_vld, tx_gt;
    logic [1:0] tx_ch, tx_qid;
    logic [7:0] tx_path;
    logic [4:0] tx_credits;
    logic [3:0] tx_words;

    int lvl [NCH];
    always_comb for (int i = 0; i < NCH; i++) src_level[i*SPC_W +: SPC_W] = SPC_W'(lvl[i]);

    nicr_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_gt(cfg_gt),
        .cfg_path(cfg_path), .cfg_qid(cfg_qid), .cfg_space(cfg_space),
        .slot_we(slot_we), .slot_idx(slot_idx), .slot_valid(slot_valid), .slot_ch(slot_ch),
        .slot_tick(slot_tick), .src_level(src_level), .cons_vld(cons_vld), .cons_ch(cons_ch),
        .rx_vld(rx_vld), .rx_ch(rx_ch), .rx_credits(rx_credits),
        .tx_vld(tx_vld), .tx_gt(tx_gt), .tx_ch(tx_ch), .tx_path(tx_path), .tx_qid(tx_qid),
        .tx_credits(tx_credits), .tx_words(tx_words)
    );

    int checks = 0, errors = 0;
    bit done = 0, comparing = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_space [NCH], m_cred [NCH], m_isgt [NCH], m_path [NCH], m_qid [NCH];
    int m_tv [SLOTS], m_tc [SLOTS];
    int m_slot, m_rr;
    bit e_vld, e_gt;
    int e_ch, e_path, e_qid, e_cred, e_words;

    function automatic int m_send(int c);
        return (lvl[c] < m_space[c]) ? lvl[c] : m_space[c];
    endfunction
    function automatic bit m_elig(int c);
        return m_send(c) > 0 || m_cred[c] > 0;
    endfunction

    always @(posedge clk) begin
        int sel, w, cr;
        bit g;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_space[i] = 0; m_cred[i] = 0; m_isgt[i] = 0; m_path[i] = 0; m_qid[i] = 0;
            end
            for (int s = 0; s < SLOTS; s++) begin m_tv[s] = 0; m_tc[s] = 0; end
            m_slot = 0; m_rr = NCH - 1; e_vld = 0; e_gt = 0;
        end else begin
            sel = -1; g = 0; w = 0; cr = 0;
            if (slot_tick) begin
                if (m_tv[m_slot] != 0 && m_elig(m_tc[m_slot])) begin
                    sel = m_tc[m_slot]; g = 1;
                end else begin
                    for (int k = 1; k <= NCH; k++) begin
                        automatic int idx = (m_rr + k) % NCH;
                        if (sel < 0 && m_isgt[idx] == 0 && m_elig(idx)) sel = idx;
                    end
                    if (sel >= 0) m_rr = sel;
                end
                m_slot = (m_slot + 1) % SLOTS;
            end
            if (sel >= 0) begin
                w  = m_send(sel); if (w > MAXW) w = MAXW;
                cr = (m_cred[sel] > CAP) ? CAP : m_cred[sel];
                e_ch = sel; e_path = m_path[sel]; e_qid = m_qid[sel]; e_cred = cr; e_words = w;
            end
            e_vld = (sel >= 0); e_gt = g;
            if (rx_vld) m_space[rx_ch] += int'(rx_credits);
            if (sel >= 0) begin m_space[sel] -= w; m_cred[sel] -= cr; end
            if (cons_vld) m_cred[cons_ch] += 1;
            if (slot_we) begin m_tv[slot_idx] = int'(slot_valid); m_tc[slot_idx] = int'(slot_ch); end
            if (cfg_we) begin
                m_space[cfg_ch] = int'(cfg_space); m_isgt[cfg_ch] = int'(cfg_gt);
                m_path[cfg_ch] = int'(cfg_path); m_qid[cfg_ch] = int'(cfg_qid);
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (comparing && rst_n) begin
            chk(tx_vld == e_vld, "R9 header valid", int'(tx_vld), int'(e_vld));
            if (tx_vld && e_vld) begin
                chk(tx_gt == e_gt, "R5 reserved-slot flag", int'(tx_gt), int'(e_gt));
                chk(int'(tx_ch) == e_ch, "R6 granted channel", int'(tx_ch), e_ch);
                chk(int'(tx_words) == e_words, "R3 R8 payload words", int'(tx_words), e_words);
                chk(int'(tx_credits) == e_cred, "R2 R7 header credits", int'(tx_credits), e_cred);
                chk(int'(tx_path) == e_path, "R1 route field", int'(tx_path), e_path);
                chk(int'(tx_qid) == e_qid, "R1 queue field", int'(tx_qid), e_qid);
            end
        end
    end

    task automatic cfg(input int ch, input bit gt, input int path, input int qid, input int sp);
        cfg_we = 1; cfg_ch = 2'(ch); cfg_gt = gt; cfg_path = 8'(path); cfg_qid = 2'(qid);
        cfg_space = 6'(sp);
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic rsv(input int idx, input int ch);
        slot_we = 1; slot_idx = 4'(idx); slot_valid = 1; slot_ch = 2'(ch);
        @(negedge clk); slot_we = 0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_gt = 0; cfg_path = 0; cfg_qid = 0; cfg_space = 0;
        slot_we = 0; slot_idx = 0; slot_valid = 0; slot_ch = 0; slot_tick = 0;
        cons_vld = 0; cons_ch = 0; rx_vld = 0; rx_ch = 0; rx_credits = 0;
        for (int i = 0; i < NCH; i++) lvl[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
        chk(tx_vld == 0, "R1 no header after reset", int'(tx_vld), 0);
        comparing = 1;

        // Phase 1: mixed classes, reserved slots, overlapping credit return
        cfg(0, 0, 8'h11, 1, 20);
        cfg(1, 0, 8'h22, 2, 5);
        cfg(2, 1, 8'h33, 3, 30);
        cfg(3, 0, 8'h44, 0, 8);
        rsv(3, 2); rsv(10, 2); rsv(7, 0);
        lvl[0] = 15; lvl[1] = 3; lvl[2] = 12; lvl[3] = 0;
        for (int c = 0; c < 80; c++) begin
            slot_tick = (c % 2 == 0);
            rx_vld = (c % 5 == 0); rx_ch = 2'(c % 3); rx_credits = 5'd4;
            if (rx_vld && m_space[rx_ch] + 4 > 63) rx_vld = 0;
            cons_vld = (c % 3 == 1); cons_ch = 2'(c % 4);
            @(negedge clk);
        end
        slot_tick = 0; rx_vld = 0; cons_vld = 0;

        // Phase 2: credit-only packets and the header credit cap
        for (int i = 0; i < NCH; i++) lvl[i] = 0;
        slot_tick = 1;
        repeat (30) @(negedge clk);
        slot_tick = 0;
        repeat (2) @(negedge clk);
        cons_ch = 2'd3; cons_vld = 1;
        repeat (40) @(negedge clk);
        cons_vld = 0;
        slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
        chk(tx_vld == 1 && tx_ch == 3, "R4 credit-only channel granted", int'(tx_ch), 3);
        chk(tx_words == 0, "R4 empty payload", int'(tx_words), 0);
        chk(tx_credits == 5'd31, "R7 credits capped", int'(tx_credits), 31);
        slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
        chk(tx_credits == 5'd9, "R7 excess credits follow", int'(tx_credits), 9);
        slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
        chk(tx_vld == 0, "R4 nothing eligible", int'(tx_vld), 0);

        // Phase 3: randomized traffic
        for (int c = 0; c < 6000; c++) begin
            slot_tick = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 15) == 0) lvl[$urandom_range(0, NCH-1)] = $urandom_range(0, 40);
            cons_ch = 2'($urandom_range(0, NCH-1));
            cons_vld = ($urandom_range(0, 2) == 0) && (m_cred[cons_ch] < 100);
            rx_ch = 2'($urandom_range(0, NCH-1));
            rx_credits = 5'($urandom_range(0, 31));
            rx_vld = ($urandom_range(0, 3) == 0) && (m_space[rx_ch] + int'(rx_credits) <= 63);
            slot_we = ($urandom_range(0, 63) == 0);
            slot_idx = 4'($urandom_range(0, 15));
            slot_valid = 1'($urandom_range(0, 1));
            slot_ch = 2'($urandom_range(0, NCH-1));
            @(negedge clk);
        end
        slot_tick = 0; cons_vld = 0; rx_vld = 0; slot_we = 0;
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule